// File: doc/BRIEF.md
# Terminal Built-In-Test Status Word

This block keeps the 16-bit built-in-test status word for one remote terminal on a MIL-STD-1553 style bus. Transmit-inhibit pins, transmitter and receiver shutdown strobes, and self-test result strobes each set their own status bit. Once set, a bit stays set until the master reset or an allowed host write changes it. The host sees the word on a plain output. With a single write strobe it may rewrite the user field and the two loopback-fail bits. A software terminal reset leaves the word alone.

A transmit-BIT-word mode command takes a snapshot of the word when the alternate-word configuration bit is clear. The snapshot goes out on a valid/ready response stream. When the command's completion strobe arrives, the same snapshot goes out on a second valid/ready stream as a write request to the terminal's data buffer. That request is tagged with the instance number, which is set by parameter.

Back-pressure rules are the same on both streams. Valid stays high and the data stays fixed until ready is seen high at a clock edge. A new snapshot taken while the response is still waiting replaces it. A software terminal reset drops any pending response and any pending buffer write.

Top module: `rt_bit_status`

## Requirements
- R1: `rst_n` is a synchronous active-low master reset. While it is low, bits 13, 12, 11..4 and 0 become 0. Bits 15 and 14 take the levels of `txinh_a` and `txinh_b`. Bits 3, 2 and 1 take the levels of `mem_test_fail`, `autoinit_fail` and `addr_par_err`. Both stream valids drop to 0.
- R2: Bit 15 (bus A) and bit 14 (bus B) are set when the matching `txinh_*` pin or the matching `shd_tx_*` strobe is high. They stay set afterwards, and host writes do not change them.
- R3: Bit 13 (bus A) and bit 12 (bus B) are set only when `shd_rx_*` and `shd_tx_*` of the same bus are high in the same cycle. A receiver strobe on its own has no effect.
- R4: A cycle with `host_wr_en` high loads bits 11..4 from `host_wr_data`. Bits 15..12 and 3..0 ignore the write, and bit 0 always reads 0.
- R5: Bit 5 is set by `lpbk_fail_a` and bit 4 by `lpbk_fail_b`. When one of these sets its bit in the same cycle as a host write, the set wins over the written value.
- R6: Bit 3 is set by `mem_test_fail`, bit 2 by `autoinit_fail` and bit 1 by `addr_par_err`. These bits are sticky and ignore host writes.
- R7: `sw_term_reset` does not change `bit_word`. It clears `resp_valid` and `bufw_valid`, and it discards a snapshot that has not yet been written to the buffer.
- R8: A cycle with `mc19_strobe` high and `alt_bitw` low captures `bit_word` as it stands in that cycle, before any update made in the same cycle. From the next cycle `resp_data` shows the capture and `resp_valid` is 1. Both hold until `resp_ready` is seen; a later capture replaces the data.
- R9: While `alt_bitw` is 1, `mc19_strobe` takes no snapshot and produces no response and no buffer write.
- R10: `mc19_done` after a capture raises `bufw_valid` in the next cycle, with `bufw_data` equal to the snapshot and `bufw_term` equal to `TERM_ID`. The request holds until `bufw_ready` is seen. `mc19_done` with no snapshot pending, or in the same cycle as a capture, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, synchronous, active low |
| sw_term_reset | input | 1 | Software terminal reset strobe |
| txinh_a | input | 1 | Bus A transmit inhibit pin |
| txinh_b | input | 1 | Bus B transmit inhibit pin |
| shd_tx_a | input | 1 | Shutdown command disables bus A transmitter |
| shd_tx_b | input | 1 | Shutdown command disables bus B transmitter |
| shd_rx_a | input | 1 | Shutdown command also disables bus A receiver |
| shd_rx_b | input | 1 | Shutdown command also disables bus B receiver |
| lpbk_fail_a | input | 1 | Self-test loopback failure on bus A |
| lpbk_fail_b | input | 1 | Self-test loopback failure on bus B |
| mem_test_fail | input | 1 | Memory self-test failure |
| autoinit_fail | input | 1 | Auto-initialization failure |
| addr_par_err | input | 1 | Terminal address parity error |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 16 | Host write data |
| alt_bitw | input | 1 | Alternate BIT word selected (block stays silent) |
| mc19_strobe | input | 1 | Valid transmit-BIT-word command seen |
| mc19_done | input | 1 | Transmit-BIT-word command completed |
| bit_word | output | 16 | Current status word |
| resp_valid | output | 1 | Response data word valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_data | output | 16 | Response data word (snapshot) |
| bufw_valid | output | 1 | Buffer write request valid |
| bufw_ready | input | 1 | Buffer writer ready |
| bufw_data | output | 16 | Word to store in the command's buffer |
| bufw_term | output | TERM_W | Terminal instance number |

## Verification
The bench builds the block with `TERM_W` = 3 and `TERM_ID` = 5. With a non-zero instance number, a tag that is wired wrong or dropped shows up on `bufw_term`, which it would not with the default of zero. The bench holds both ready inputs low for several cycles, so the hold and replace rules of the two streams are exercised. It also drives host writes in the same cycle as capture and loopback strobes, which covers the same-cycle priority and the capture-before-update behaviour.

// File: rtl/rt_bit_pkg.sv
package rt_bit_pkg;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] bit_word_t;

  // Bit positions; downstream software decodes these, so they are fixed.
  localparam int POS_TXA   = 15;
  localparam int POS_TXB   = 14;
  localparam int POS_RXA   = 13;
  localparam int POS_RXB   = 12;
  localparam int POS_LBA   = 5;
  localparam int POS_LBB   = 4;
  localparam int POS_MEM   = 3;
  localparam int POS_AINIT = 2;
  localparam int POS_APAR  = 1;

  // Bits the host may rewrite.
  localparam bit_word_t HOST_WR_MASK = 16'h0FF0;
  // Bits that follow their source level during master reset (others clear).
  localparam bit_word_t RELOAD_MASK  = 16'hC00E;
endpackage

// File: rtl/rt_bit_events.sv
module rt_bit_events
  import rt_bit_pkg::*;
(
  input  logic      txinh_a,
  input  logic      txinh_b,
  input  logic      shd_tx_a,
  input  logic      shd_tx_b,
  input  logic      shd_rx_a,
  input  logic      shd_rx_b,
  input  logic      lpbk_fail_a,
  input  logic      lpbk_fail_b,
  input  logic      mem_test_fail,
  input  logic      autoinit_fail,
  input  logic      addr_par_err,
  output bit_word_t set_vec,
  output bit_word_t reload_vec
);
  always_comb begin
    set_vec            = '0;
    set_vec[POS_TXA]   = txinh_a | shd_tx_a;
    set_vec[POS_TXB]   = txinh_b | shd_tx_b;
    set_vec[POS_RXA]   = shd_tx_a & shd_rx_a;
    set_vec[POS_RXB]   = shd_tx_b & shd_rx_b;
    set_vec[POS_LBA]   = lpbk_fail_a;
    set_vec[POS_LBB]   = lpbk_fail_b;
    set_vec[POS_MEM]   = mem_test_fail;
    set_vec[POS_AINIT] = autoinit_fail;
    set_vec[POS_APAR]  = addr_par_err;
  end

  always_comb begin
    reload_vec            = '0;
    reload_vec[POS_TXA]   = txinh_a;
    reload_vec[POS_TXB]   = txinh_b;
    reload_vec[POS_MEM]   = mem_test_fail;
    reload_vec[POS_AINIT] = autoinit_fail;
    reload_vec[POS_APAR]  = addr_par_err;
  end
endmodule

// File: rtl/rt_bit_cell.sv
module rt_bit_cell #(
  parameter bit RELOAD_ON_MR = 1'b0,
  parameter bit HOST_WR      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic reload_i,
  input  logic host_we,
  input  logic host_d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= RELOAD_ON_MR ? reload_i : 1'b0;
    else if (set_i)
      q <= 1'b1;
    else if (HOST_WR && host_we)
      q <= host_d;
  end
endmodule

// File: rtl/rt_bit_snap.sv
module rt_bit_snap
  import rt_bit_pkg::*;
#(
  parameter int TERM_W  = 4,
  parameter int TERM_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_term_reset,
  input  logic              alt_bitw,
  input  logic              mc19_strobe,
  input  logic              mc19_done,
  input  bit_word_t         word_i,
  output logic              resp_valid,
  input  logic              resp_ready,
  output bit_word_t         resp_data,
  output logic              bufw_valid,
  input  logic              bufw_ready,
  output bit_word_t         bufw_data,
  output logic [TERM_W-1:0] bufw_term
);
  localparam logic [TERM_W-1:0] TERM_TAG = TERM_W'(TERM_ID);

  logic capture;
  logic pending;

  assign capture   = mc19_strobe & ~alt_bitw;
  assign bufw_term = TERM_TAG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      pending    <= 1'b0;
      bufw_valid <= 1'b0;
      bufw_data  <= '0;
    end else if (sw_term_reset) begin
      resp_valid <= 1'b0;
      pending    <= 1'b0;
      bufw_valid <= 1'b0;
    end else begin
      if (capture) begin
        resp_data  <= word_i;
        resp_valid <= 1'b1;
        pending    <= 1'b1;
      end else if (resp_valid && resp_ready) begin
        resp_valid <= 1'b0;
      end

      if (mc19_done && pending && !capture) begin
        bufw_valid <= 1'b1;
        bufw_data  <= resp_data;
        pending    <= 1'b0;
      end else if (bufw_valid && bufw_ready) begin
        bufw_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rt_bit_status.sv
module rt_bit_status
  import rt_bit_pkg::*;
#(
  parameter int TERM_W  = 4,
  parameter int TERM_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_term_reset,
  input  logic              txinh_a,
  input  logic              txinh_b,
  input  logic              shd_tx_a,
  input  logic              shd_tx_b,
  input  logic              shd_rx_a,
  input  logic              shd_rx_b,
  input  logic              lpbk_fail_a,
  input  logic              lpbk_fail_b,
  input  logic              mem_test_fail,
  input  logic              autoinit_fail,
  input  logic              addr_par_err,
  input  logic              host_wr_en,
  input  logic [15:0]       host_wr_data,
  input  logic              alt_bitw,
  input  logic              mc19_strobe,
  input  logic              mc19_done,
  output logic [15:0]       bit_word,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [15:0]       resp_data,
  output logic              bufw_valid,
  input  logic              bufw_ready,
  output logic [15:0]       bufw_data,
  output logic [TERM_W-1:0] bufw_term
);
  bit_word_t set_vec;
  bit_word_t reload_vec;
  bit_word_t word_q;

  rt_bit_events u_events (
    .txinh_a       (txinh_a),
    .txinh_b       (txinh_b),
    .shd_tx_a      (shd_tx_a),
    .shd_tx_b      (shd_tx_b),
    .shd_rx_a      (shd_rx_a),
    .shd_rx_b      (shd_rx_b),
    .lpbk_fail_a   (lpbk_fail_a),
    .lpbk_fail_b   (lpbk_fail_b),
    .mem_test_fail (mem_test_fail),
    .autoinit_fail (autoinit_fail),
    .addr_par_err  (addr_par_err),
    .set_vec       (set_vec),
    .reload_vec    (reload_vec)
  );

  for (genvar i = 0; i < WORD_W; i++) begin : g_cell
    rt_bit_cell #(
      .RELOAD_ON_MR (RELOAD_MASK[i]),
      .HOST_WR      (HOST_WR_MASK[i])
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_vec[i]),
      .reload_i (reload_vec[i]),
      .host_we  (host_wr_en),
      .host_d   (host_wr_data[i]),
      .q        (word_q[i])
    );
  end

  assign bit_word = word_q;

  rt_bit_snap #(
    .TERM_W  (TERM_W),
    .TERM_ID (TERM_ID)
  ) u_snap (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_term_reset (sw_term_reset),
    .alt_bitw      (alt_bitw),
    .mc19_strobe   (mc19_strobe),
    .mc19_done     (mc19_done),
    .word_i        (word_q),
    .resp_valid    (resp_valid),
    .resp_ready    (resp_ready),
    .resp_data     (resp_data),
    .bufw_valid    (bufw_valid),
    .bufw_ready    (bufw_ready),
    .bufw_data     (bufw_data),
    .bufw_term     (bufw_term)
  );
endmodule

// File: rtl/rt_bit_status_chk.sv
module rt_bit_status_chk #(
  parameter int TERM_W  = 4,
  parameter int TERM_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_term_reset,
  input logic              txinh_a,
  input logic              txinh_b,
  input logic              shd_tx_a,
  input logic              shd_tx_b,
  input logic              lpbk_fail_a,
  input logic              lpbk_fail_b,
  input logic              mem_test_fail,
  input logic              autoinit_fail,
  input logic              addr_par_err,
  input logic              host_wr_en,
  input logic              alt_bitw,
  input logic              mc19_strobe,
  input logic [15:0]       bit_word,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [15:0]       resp_data,
  input logic              bufw_valid,
  input logic [15:0]       bufw_data,
  input logic [TERM_W-1:0] bufw_term
);
  logic quiet;
  assign quiet = !(txinh_a | txinh_b | shd_tx_a | shd_tx_b | lpbk_fail_a | lpbk_fail_b |
                   mem_test_fail | autoinit_fail | addr_par_err | host_wr_en);

  // R7 (and stickiness): with no set source and no write, nothing moves,
  // whatever sw_term_reset does.
  assert_word_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(bit_word));

  assert_bit0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_word[0]);

  assert_rx_a_implies_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_word[13] |-> bit_word[15]);

  assert_rx_b_implies_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_word[12] |-> bit_word[14]);

  assert_lpbk_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lpbk_fail_a |=> bit_word[5]);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mc19_strobe && !alt_bitw && !sw_term_reset) |=>
      (resp_valid && resp_data == $past(bit_word)));

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready && !sw_term_reset && !(mc19_strobe && !alt_bitw)) |=>
      (resp_valid && $stable(resp_data)));

  assert_alt_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mc19_strobe && alt_bitw && !resp_valid) |=> !resp_valid);

  assert_bufw_snapshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bufw_valid) |-> (bufw_data == resp_data && bufw_term == TERM_W'(TERM_ID)));
endmodule

bind rt_bit_status rt_bit_status_chk #(.TERM_W(TERM_W), .TERM_ID(TERM_ID)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_term_reset (sw_term_reset),
  .txinh_a       (txinh_a),
  .txinh_b       (txinh_b),
  .shd_tx_a      (shd_tx_a),
  .shd_tx_b      (shd_tx_b),
  .lpbk_fail_a   (lpbk_fail_a),
  .lpbk_fail_b   (lpbk_fail_b),
  .mem_test_fail (mem_test_fail),
  .autoinit_fail (autoinit_fail),
  .addr_par_err  (addr_par_err),
  .host_wr_en    (host_wr_en),
  .alt_bitw      (alt_bitw),
  .mc19_strobe   (mc19_strobe),
  .bit_word      (bit_word),
  .resp_valid    (resp_valid),
  .resp_ready    (resp_ready),
  .resp_data     (resp_data),
  .bufw_valid    (bufw_valid),
  .bufw_data     (bufw_data),
  .bufw_term     (bufw_term)
);

// File: tb/rt_bit_status_test.sv
module rt_bit_status_test;
  localparam int TW  = 3;
  localparam int TID = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_term_reset = 0, txinh_a = 0, txinh_b = 0;
  logic shd_tx_a = 0, shd_tx_b = 0, shd_rx_a = 0, shd_rx_b = 0;
  logic lpbk_fail_a = 0, lpbk_fail_b = 0;
  logic mem_test_fail = 0, autoinit_fail = 0, addr_par_err = 0;
  logic host_wr_en = 0;
  logic [15:0] host_wr_data = '0;
  logic alt_bitw = 0, mc19_strobe = 0, mc19_done = 0;
  logic resp_ready = 0, bufw_ready = 0;
  logic [15:0] bit_word, resp_data, bufw_data;
  logic resp_valid, bufw_valid;
  logic [TW-1:0] bufw_term;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rt_bit_status #(.TERM_W(TW), .TERM_ID(TID)) uut (
    .clk(clk), .rst_n(rst_n), .sw_term_reset(sw_term_reset),
    .txinh_a(txinh_a), .txinh_b(txinh_b),
    .shd_tx_a(shd_tx_a), .shd_tx_b(shd_tx_b),
    .shd_rx_a(shd_rx_a), .shd_rx_b(shd_rx_b),
    .lpbk_fail_a(lpbk_fail_a), .lpbk_fail_b(lpbk_fail_b),
    .mem_test_fail(mem_test_fail), .autoinit_fail(autoinit_fail),
    .addr_par_err(addr_par_err),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .alt_bitw(alt_bitw), .mc19_strobe(mc19_strobe), .mc19_done(mc19_done),
    .bit_word(bit_word),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .bufw_valid(bufw_valid), .bufw_ready(bufw_ready), .bufw_data(bufw_data),
    .bufw_term(bufw_term)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] d);
    host_wr_en = 1; host_wr_data = d;
    tick();
    host_wr_en = 0; host_wr_data = '0;
  endtask

  task automatic do_mr();
    rst_n = 0;
    tick();
    rst_n = 1;
  endtask

  task automatic t_reset();
    txinh_a = 1; mem_test_fail = 1;
    tick(); tick();
    chk("R1 reload during reset", bit_word, 16'h8008);
    chk("R1 resp_valid in reset", resp_valid, 0);
    chk("R1 bufw_valid in reset", bufw_valid, 0);
    rst_n = 1; txinh_a = 0; mem_test_fail = 0;
    tick();
    chk("R1 reloaded bits sticky", bit_word, 16'h8008);
    host_write(16'h0FF0);
    shd_tx_b = 1; shd_rx_b = 1;
    tick();
    shd_tx_b = 0; shd_rx_b = 0;
    chk("R1 setup before reset", bit_word, 16'hDFF8);
    rst_n = 0; txinh_b = 1; autoinit_fail = 1;
    tick();
    chk("R1 selective clear", bit_word, 16'h4004);
    rst_n = 1; txinh_b = 0; autoinit_fail = 0;
    tick();
  endtask

  task automatic t_tx_shutdown();
    do_mr();
    txinh_b = 1; tick(); txinh_b = 0;
    chk("R2 txinh_b sets bit14", bit_word, 16'h4000);
    tick();
    chk("R2 bit14 sticky", bit_word, 16'h4000);
    shd_tx_a = 1; tick(); shd_tx_a = 0;
    chk("R2 shd_tx_a sets bit15", bit_word, 16'hC000);
    host_write(16'h0000);
    chk("R2 host cannot clear", bit_word, 16'hC000);
  endtask

  task automatic t_rx_shutdown();
    do_mr();
    shd_rx_a = 1; tick(); shd_rx_a = 0;
    chk("R3 rx_a alone ignored", bit_word, 16'h0000);
    shd_rx_b = 1; tick(); shd_rx_b = 0;
    chk("R3 rx_b alone ignored", bit_word, 16'h0000);
    shd_tx_a = 1; shd_rx_a = 1; tick(); shd_tx_a = 0; shd_rx_a = 0;
    chk("R3 joint A sets 15 and 13", bit_word, 16'hA000);
    shd_tx_b = 1; tick(); shd_tx_b = 0;
    chk("R3 tx_b alone no bit12", bit_word, 16'hE000);
  endtask

  task automatic t_host();
    do_mr();
    host_write(16'hFFFF);
    chk("R4 write all ones", bit_word, 16'h0FF0);
    host_write(16'hA5A5);
    chk("R4 write pattern", bit_word, 16'h05A0);
    host_write(16'h0000);
    chk("R4 write zero", bit_word, 16'h0000);
  endtask

  task automatic t_loopback();
    do_mr();
    lpbk_fail_a = 1; host_wr_en = 1; host_wr_data = 16'h0000;
    tick();
    lpbk_fail_a = 0; host_wr_en = 0;
    chk("R5 set beats write bit5", bit_word, 16'h0020);
    host_write(16'h0000);
    chk("R5 host clears bit5", bit_word, 16'h0000);
    lpbk_fail_b = 1; tick(); lpbk_fail_b = 0;
    chk("R5 lpbk_b sets bit4", bit_word, 16'h0010);
    lpbk_fail_a = 1; host_wr_en = 1; host_wr_data = 16'h0010;
    tick();
    lpbk_fail_a = 0; host_wr_en = 0;
    chk("R5 mixed write and set", bit_word, 16'h0030);
  endtask

  task automatic t_errors();
    do_mr();
    addr_par_err = 1; tick(); addr_par_err = 0;
    chk("R6 parity bit1", bit_word, 16'h0002);
    autoinit_fail = 1; tick(); autoinit_fail = 0;
    chk("R6 autoinit bit2", bit_word, 16'h0006);
    mem_test_fail = 1; tick(); mem_test_fail = 0;
    chk("R6 memtest bit3", bit_word, 16'h000E);
    host_write(16'h0000);
    chk("R6 write ignored", bit_word, 16'h000E);
  endtask

  task automatic t_sw_reset();
    do_mr();
    host_write(16'h0550);
    sw_term_reset = 1; tick(); sw_term_reset = 0;
    chk("R7 word kept", bit_word, 16'h0550);
    mc19_strobe = 1; tick(); mc19_strobe = 0;
    mc19_done = 1; tick(); mc19_done = 0;
    chk("R7 setup bufw", bufw_valid, 1);
    sw_term_reset = 1; tick(); sw_term_reset = 0;
    chk("R7 resp dropped", resp_valid, 0);
    chk("R7 bufw dropped", bufw_valid, 0);
    chk("R7 word kept after", bit_word, 16'h0550);
    mc19_done = 1; tick(); mc19_done = 0;
    chk("R7 snapshot discarded", bufw_valid, 0);
  endtask

  task automatic t_mc19();
    do_mr();
    host_write(16'h0330);
    mc19_strobe = 1; host_wr_en = 1; host_wr_data = 16'h0FF0;
    tick();
    mc19_strobe = 0; host_wr_en = 0;
    chk("R8 valid after capture", resp_valid, 1);
    chk("R8 pre-update value", resp_data, 16'h0330);
    chk("R8 word updated", bit_word, 16'h0FF0);
    tick(); tick();
    chk("R8 valid held", resp_valid, 1);
    chk("R8 data held", resp_data, 16'h0330);
    mc19_strobe = 1; tick(); mc19_strobe = 0;
    chk("R8 replace data", resp_data, 16'h0FF0);
    resp_ready = 1; tick(); resp_ready = 0;
    chk("R8 accepted", resp_valid, 0);
  endtask

  task automatic t_alt();
    do_mr();
    alt_bitw = 1;
    host_write(16'h0100);
    mc19_strobe = 1; tick(); mc19_strobe = 0;
    chk("R9 no response", resp_valid, 0);
    mc19_done = 1; tick(); mc19_done = 0;
    chk("R9 no buffer write", bufw_valid, 0);
    alt_bitw = 0;
  endtask

  task automatic t_bufw();
    do_mr();
    mc19_done = 1; tick(); mc19_done = 0;
    chk("R10 done without capture", bufw_valid, 0);
    host_write(16'h0440);
    mc19_strobe = 1; tick(); mc19_strobe = 0;
    resp_ready = 1; tick(); resp_ready = 0;
    host_write(16'h0000);
    mc19_done = 1; tick(); mc19_done = 0;
    chk("R10 bufw valid", bufw_valid, 1);
    chk("R10 bufw data", bufw_data, 16'h0440);
    chk("R10 bufw term", bufw_term, TID);
    tick();
    chk("R10 bufw held", bufw_valid, 1);
    bufw_ready = 1; tick(); bufw_ready = 0;
    chk("R10 bufw accepted", bufw_valid, 0);
    mc19_done = 1; tick(); mc19_done = 0;
    chk("R10 second done ignored", bufw_valid, 0);
  endtask

  initial begin
    t_reset();
    t_tx_shutdown();
    t_rx_shutdown();
    t_host();
    t_loopback();
    t_errors();
    t_sw_reset();
    t_mc19();
    t_alt();
    t_bufw();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule